// File: doc/BRIEF.md
# Serial Port Transmit Clock Generator

This block produces the transmit clock for a synchronous serial port, entirely inside the master-clock domain. A programmable divider makes a divided clock with an exact 50% duty cycle. The divider can be switched off by loading zero. A selector then chooses the transmit clock from one of three sources: the receiver clock level, the divided clock, or an external pad clock. The pad clock is brought into the domain through a two-flop synchronizer.

The selected clock can be inverted before it reaches the internal transmitter. The inversion never affects the clock sent back out to the pad. The pad driver runs continuously or only while a transfer is active. It is disabled when the pad is both the source and the continuous destination, since that would form a loop. Downstream logic does not use a derived clock. It uses single-cycle rise and fall strobes of the internal transmit clock, and separate strobes for the synchronized pad input.

Top module: `txclk_gen`

## Requirements
- R1: After reset, with the divide value at 0, no transfer active and the transmit-only pad mode selected, `div_clk`, `tx_rise`, `tx_fall` and `pad_oe` are all 0.
- R2: While `div_val` is 0, `div_clk` stays low and never toggles.
- R3: For `div_val` = D with 1 ≤ D ≤ 4095, each high level and each low level of `div_clk` lasts exactly D master-clock cycles, for both odd and even D. D=1 gives clk/2, and the slowest clock is clk/8190.
- R4: When `div_val` changes to a new value D ≥ 1, the count restarts at the next clock edge. `div_clk` is then low for D cycles before its first rise.
- R5: `src_sel` picks the source: 0 = `rx_clk`, 1 = `div_clk`, 2 = synchronized pad level `pad_sync`, 3 = constant low. `pad_clk_out` equals the selected source.
- R6: `tx_clk` equals the selected source XOR `invert`. `invert` has no effect on `pad_clk_out`.
- R7: With `out_mode` = 1 (continuous), `pad_oe` is 1. With `out_mode` = 0, `pad_oe` follows `xfer_active`. With `src_sel` = 2 and `out_mode` = 1, `pad_oe` is forced to 0.
- R8: `pad_sync` takes the value of `pad_clk_in` after two clock edges. `pad_rise` and `pad_fall` are 1 for exactly the one cycle in which `pad_sync` has just risen or just fallen.
- R9: `tx_rise` is 1 exactly in a cycle where `tx_clk` is 1 and was 0 in the previous cycle. `tx_fall` is the mirror case. The two strobes are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | DIV_W | Divide value; 0 disables the divider |
| src_sel | input | 2 | Transmit clock source select |
| invert | input | 1 | Invert the internal transmit clock |
| out_mode | input | 1 | 1 = continuous pad drive, 0 = only during transfer |
| xfer_active | input | 1 | A data transfer is in progress |
| rx_clk | input | 1 | Receiver clock level, already in the clk domain |
| pad_clk_in | input | 1 | Asynchronous external clock from the pad |
| div_clk | output | 1 | Divided clock, shared with the receiver side |
| pad_sync | output | 1 | Synchronized pad clock level |
| pad_rise | output | 1 | One-cycle strobe on a rising edge of pad_sync |
| pad_fall | output | 1 | One-cycle strobe on a falling edge of pad_sync |
| tx_clk | output | 1 | Internal transmit clock after optional inversion |
| tx_rise | output | 1 | One-cycle strobe on a rising edge of tx_clk |
| tx_fall | output | 1 | One-cycle strobe on a falling edge of tx_clk |
| pad_clk_out | output | 1 | Clock driven to the pad, never inverted |
| pad_oe | output | 1 | Pad output enable |

## Verification
The hardest case to reach is an exact level duration at the extremes of the divider: a full 4095-cycle half period, and the restart that a new divide value causes partway through a level. The stimulus passes through a zero value before each new divisor, so the restart happens at a known edge. It then counts sampled levels across three consecutive half periods, for divisors 1, 2, 3, 4095 and a set of random values. The pad-source loop case is reached by random sweeps of source, mode and transfer flag. Directed pad toggles check the two-edge synchronizer latency and the width of the strobes.

// File: rtl/txclk_gen.sv
module txclk_gen #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  input  logic [1:0]       src_sel,
  input  logic             invert,
  input  logic             out_mode,
  input  logic             xfer_active,
  input  logic             rx_clk,
  input  logic             pad_clk_in,
  output logic             div_clk,
  output logic             pad_sync,
  output logic             pad_rise,
  output logic             pad_fall,
  output logic             tx_clk,
  output logic             tx_rise,
  output logic             tx_fall,
  output logic             pad_clk_out,
  output logic             pad_oe
);

  localparam logic [1:0] SRC_RX  = 2'd0;
  localparam logic [1:0] SRC_DIV = 2'd1;
  localparam logic [1:0] SRC_PAD = 2'd2;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt;
  logic             pad_s1, pad_s2, pad_s3;
  logic             tx_prev;
  logic             sel_clk;

  // divider: level held for div_q cycles, restart on new value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      cnt     <= '0;
      div_clk <= 1'b0;
    end else if (div_val != div_q) begin
      div_q   <= div_val;
      cnt     <= '0;
      div_clk <= 1'b0;
    end else if (div_q == '0) begin
      cnt     <= '0;
      div_clk <= 1'b0;
    end else if (cnt == div_q - 1'b1) begin
      cnt     <= '0;
      div_clk <= ~div_clk;
    end else begin
      cnt     <= cnt + 1'b1;
    end
  end

  // pad clock synchronizer and edge history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_s1  <= 1'b0;
      pad_s2  <= 1'b0;
      pad_s3  <= 1'b0;
      tx_prev <= 1'b0;
    end else begin
      pad_s1  <= pad_clk_in;
      pad_s2  <= pad_s1;
      pad_s3  <= pad_s2;
      tx_prev <= tx_clk;
    end
  end

  assign pad_sync = pad_s2;
  assign pad_rise = pad_s2 & ~pad_s3;
  assign pad_fall = ~pad_s2 & pad_s3;

  always_comb begin
    case (src_sel)
      SRC_RX:  sel_clk = rx_clk;
      SRC_DIV: sel_clk = div_clk;
      SRC_PAD: sel_clk = pad_s2;
      default: sel_clk = 1'b0;
    endcase
  end

  assign tx_clk      = sel_clk ^ invert;
  assign tx_rise     = tx_clk & ~tx_prev;
  assign tx_fall     = ~tx_clk & tx_prev;
  assign pad_clk_out = sel_clk;
  assign pad_oe      = (out_mode | xfer_active) & ~(out_mode & (src_sel == SRC_PAD));

  p_div_zero_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (div_val == '0) |=> !div_clk);

  p_restart_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (div_val != div_q) |=> (!div_clk && cnt == '0));

  p_level_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (div_val == div_q && div_q != '0 && cnt != div_q - 1'b1) |=> $stable(div_clk));

  p_no_loop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == SRC_PAD && out_mode) |-> !pad_oe);

  p_pad_raw_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == SRC_DIV) |-> (pad_clk_out == div_clk));

  p_pad_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pad_rise |=> !pad_rise);

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_rise && tx_fall));

endmodule

// File: tb/txclk_gen_tb.sv
module txclk_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DIV_W-1:0] div_val = '0;
  logic [1:0] src_sel = 2'd0;
  logic invert = 1'b0, out_mode = 1'b0, xfer_active = 1'b0;
  logic rx_clk = 1'b0, pad_clk_in = 1'b0;
  logic div_clk, pad_sync, pad_rise, pad_fall, tx_clk, tx_rise, tx_fall, pad_clk_out, pad_oe;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txclk_gen #(.DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .src_sel(src_sel), .invert(invert),
    .out_mode(out_mode), .xfer_active(xfer_active), .rx_clk(rx_clk), .pad_clk_in(pad_clk_in),
    .div_clk(div_clk), .pad_sync(pad_sync), .pad_rise(pad_rise), .pad_fall(pad_fall),
    .tx_clk(tx_clk), .tx_rise(tx_rise), .tx_fall(tx_fall), .pad_clk_out(pad_clk_out), .pad_oe(pad_oe)
  );

  function automatic logic exp_src(logic [1:0] s, logic rx, logic dv, logic ps);
    case (s)
      2'd0: return rx;
      2'd1: return dv;
      2'd2: return ps;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic exp_oe(logic [1:0] s, logic m, logic x);
    if (s == 2'd2 && m) return 1'b0;
    return m | x;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count consecutive samples at level lvl (sampling on negedges), checking tx strobes
  task automatic run_len(logic lvl, output int n);
    logic prev;
    n = 0;
    prev = tx_clk;
    while (div_clk == lvl && n < 9000) begin
      n++;
      @(negedge clk);
      chk(tx_rise == (tx_clk && !prev), "R9 tx_rise", tx_rise, tx_clk && !prev);
      chk(tx_fall == (!tx_clk && prev), "R9 tx_fall", tx_fall, !tx_clk && prev);
      prev = tx_clk;
    end
  endtask

  task automatic check_div(int d);
    int n;
    div_val = '0;
    @(negedge clk);
    div_val = d[DIV_W-1:0];
    @(negedge clk);
    run_len(1'b0, n);
    chk(n == d, "R4 first low after restart", n, d);
    run_len(1'b1, n);
    chk(n == d, "R3 high level", n, d);
    run_len(1'b0, n);
    chk(n == d, "R3 low level", n, d);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    int zeros;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk(div_clk == 0, "R1 div_clk reset", div_clk, 0);
    chk(tx_rise == 0 && tx_fall == 0, "R1 strobes reset", tx_rise + tx_fall, 0);
    chk(pad_oe == 0, "R1 pad_oe reset", pad_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(div_clk == 0 && pad_oe == 0, "R1 after release", div_clk, 0);

    // R2: divider off
    zeros = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (div_clk == 0) zeros++;
    end
    chk(zeros == 60, "R2 div_clk low with div 0", zeros, 60);

    // R3/R4/R9 directed and random divisors
    src_sel = 2'd1;
    check_div(1);
    check_div(2);
    check_div(3);
    invert = 1'b1;
    check_div(4095);
    for (int i = 0; i < 8; i++) begin
      invert = $urandom_range(0, 1);
      check_div($urandom_range(1, 40));
    end

    // R4: change mid-level
    invert = 1'b0;
    div_val = 12'd9;
    repeat (13) @(negedge clk);
    div_val = 12'd4;
    @(negedge clk);
    begin
      int n;
      run_len(1'b0, n);
      chk(n == 4, "R4 restart mid-level", n, 4);
    end

    // R5/R6/R7 random sweeps
    for (int i = 0; i < 300; i++) begin
      src_sel = $urandom_range(0, 3);
      invert = $urandom_range(0, 1);
      out_mode = $urandom_range(0, 1);
      xfer_active = $urandom_range(0, 1);
      rx_clk = $urandom_range(0, 1);
      pad_clk_in = $urandom_range(0, 1);
      @(negedge clk);
      chk(pad_clk_out == exp_src(src_sel, rx_clk, div_clk, pad_sync), "R5 pad_clk_out",
          pad_clk_out, exp_src(src_sel, rx_clk, div_clk, pad_sync));
      chk(tx_clk == (exp_src(src_sel, rx_clk, div_clk, pad_sync) ^ invert), "R6 tx_clk",
          tx_clk, exp_src(src_sel, rx_clk, div_clk, pad_sync) ^ invert);
      chk(pad_oe == exp_oe(src_sel, out_mode, xfer_active), "R7 pad_oe",
          pad_oe, exp_oe(src_sel, out_mode, xfer_active));
    end

    // R7 directed loop case
    src_sel = 2'd2; out_mode = 1'b1; xfer_active = 1'b1;
    @(negedge clk);
    chk(pad_oe == 0, "R7 loop forced off", pad_oe, 0);

    // R8 synchronizer latency and strobes
    out_mode = 1'b0; invert = 1'b0; pad_clk_in = 1'b0;
    repeat (4) @(negedge clk);
    pad_clk_in = 1'b1;
    @(negedge clk);
    chk(pad_sync == 0, "R8 not yet after one edge", pad_sync, 0);
    @(negedge clk);
    chk(pad_sync == 1, "R8 level after two edges", pad_sync, 1);
    chk(pad_rise == 1, "R8 rise strobe", pad_rise, 1);
    chk(tx_rise == 1, "R9 tx_rise from pad", tx_rise, 1);
    @(negedge clk);
    chk(pad_rise == 0, "R8 rise one cycle", pad_rise, 0);
    pad_clk_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(pad_fall == 1 && pad_sync == 0, "R8 fall strobe", pad_fall, 1);
    @(negedge clk);
    chk(pad_fall == 0, "R8 fall one cycle", pad_fall, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule